// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block is the command front end of an SDRAM controller during power-up. Two control bits from software, `initBit` and `modeBit`, pick the phase of the power-up sequence. A change to a new bit combination issues at most one command on the SDRAM command pins: a NOP or a precharge-all. While the bits select the load phase, a single-cycle host read becomes a load-mode-register command. The mode word for that command comes from host address bits [25:11].

A programmable interval timer generates auto-refresh commands. It runs after the precharge, and again once the part is in normal operation. Software first loads a short interval so that the required burst of refreshes completes quickly, and later loads the operational value. The block enforces the order of the sequence. It rejects an early precharge and rejects a mode load that comes too early or carries a burst length that does not match the data width. Any rejection sets a sticky error flag. When the bits return to normal after a successful mode load, the block raises `initDone` and from then on forwards ordinary commands.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset the command pins show command-inhibit `{cs#,ras#,cas#,we#}=1111`, the address is 0, `refreshCount` is 0, and `initDone` and `seqErr` are low.
- R2: A change of `{initBit,modeBit}` to 11 drives exactly one NOP (0111, address 0) on the clock edge that samples the change. The block drives command-inhibit again on the following edge.
- R3: Until `PWR_WAIT` clock edges have passed since reset, only NOP or command-inhibit appears on the command pins. A precharge request in that window is refused and sets `seqErr`.
- R4: A change of the bits to 10, made after the power-up wait and after a NOP, drives one precharge-all (0010 with address bit 10 high, all other address bits 0) and clears `refreshCount`. The same change made before any NOP is refused and sets `seqErr`.
- R5: After the precharge, in phase 10 or in normal operation, an auto-refresh (0001, address 0) is issued every N clock edges, where N is `refIval`. The first refresh comes N edges after the precharge edge. Each refresh increments `refreshCount`.
- R6: When `refIval` is 0, no auto-refresh is generated.
- R7: With the bits at 01, a one-cycle host read drives a load-mode command (0000) with `sdAddr = hostAddr[25:11]`, provided a precharge was done and `refreshCount` is at least `REQ_REF` (8).
- R8: The burst-length field of the mode word, `hostAddr[13:11]`, must be 010 (length 4) when `widthSel` is 0 (32-bit path) and 011 (length 8) when `widthSel` is 1 (16-bit path). A host read with any other code is refused: the pins show command-inhibit and `seqErr` is set.
- R9: A mode-load request made before `REQ_REF` refreshes is refused: the pins show command-inhibit and `seqErr` is set. `seqErr` stays high until reset.
- R10: `initDone` rises on the edge that samples the bits changing to 00, but only after a successful mode load. Once high it stays high until reset.
- R11: With the bits at 00 and `initDone` high, `userCmd` and `userAddr` appear on the pins one edge later, except on an edge that issues a refresh. Before `initDone` the pins show command-inhibit in that phase.
- R12: `refreshCount` saturates at its all-ones value (255) and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| initBit | input | 1 | Software initialize control bit |
| modeBit | input | 1 | Software mode control bit |
| widthSel | input | 1 | Data path width: 0 = 32-bit, 1 = 16-bit |
| refIval | input | TMR_W | Refresh interval in clock cycles; 0 disables refresh |
| hostRd | input | 1 | Single-cycle host read strobe |
| hostAddr | input | HA_W | Host address; bits [25:11] carry the mode word |
| userCmd | input | 4 | Ordinary command `{cs#,ras#,cas#,we#}` for normal operation |
| userAddr | input | SD_AW | Ordinary SDRAM address for normal operation |
| sdCmd | output | 4 | SDRAM command pins `{cs#,ras#,cas#,we#}` |
| sdAddr | output | SD_AW | SDRAM address bus |
| refreshCount | output | CNT_W | Saturating count of refreshes since the last precharge |
| initDone | output | 1 | Power-up sequence complete |
| seqErr | output | 1 | Sticky flag for a refused out-of-order or mismatched request |

## Verification
The hardest state to reach is the edge where the refresh timer and the sequence rules interact. One case is a mode load attempted with just under eight refreshes counted. The other is ordinary commands losing a slot to a refresh in normal operation. The stimulus reaches both through the ports. It uses a short power-up wait and interval 10, so that 35 cycles in the precharge phase leave the count at three before a host read is tried. It also keeps a refresh interval running while varied user commands stream in after `initDone`, so that refreshes land between them. A reference model in the bench tracks every refresh slot cycle by cycle.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // command pin encodings {cs#, ras#, cas#, we#}
  localparam logic [3:0] CMD_INH = 4'b1111;
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_LMR = 4'b0000;

  // burst-length codes in mode word bits [2:0]
  localparam logic [2:0] BL4_CODE = 3'b010;
  localparam logic [2:0] BL8_CODE = 3'b011;

  // lowest host address bit carrying the mode word
  localparam int HA_LO   = 11;
  // address bit that selects all banks on precharge
  localparam int A10_BIT = 10;

  typedef enum logic [1:0] {
    M_NORMAL = 2'b00,
    M_LOAD   = 2'b01,
    M_PRECH  = 2'b10,
    M_NOP    = 2'b11
  } seqMode_t;

  typedef struct packed {
    logic nop;
    logic pre;
    logic lmr;
    logic passThru;
    logic timerEn;
    logic pwrOk;
  } seqStrb_t;

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int PWR_WAIT = 10000,
  parameter int REQ_REF  = 8,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             initBit,
  input  logic             modeBit,
  input  logic             hostRd,
  input  logic [2:0]       burstCode,
  input  logic             widthSel,
  input  logic [CNT_W-1:0] refCnt,
  output seqStrb_t         strb,
  output logic             initDone,
  output logic             seqErr
);

  localparam int PW_W = $clog2(PWR_WAIT + 1);

  logic [PW_W-1:0] pwrCnt;
  seqMode_t        modeSel, prevMode;
  logic            nopSeen, preSeen, lmrSeen;
  logic            entry, pwrOk, burstOk, refEnough;
  logic            preReq, preOk, lmrReq, lmrOk, passThru, doneSet;

  assign modeSel   = seqMode_t'({initBit, modeBit});
  assign entry     = (modeSel != prevMode);
  assign pwrOk     = (pwrCnt == PW_W'(PWR_WAIT));
  assign burstOk   = widthSel ? (burstCode == BL8_CODE) : (burstCode == BL4_CODE);
  assign refEnough = (refCnt >= CNT_W'(REQ_REF));

  assign preReq   = entry && (modeSel == M_PRECH);
  assign preOk    = preReq && pwrOk && nopSeen;
  assign lmrReq   = hostRd && (modeSel == M_LOAD);
  assign lmrOk    = lmrReq && pwrOk && preSeen && refEnough && burstOk;
  assign passThru = (modeSel == M_NORMAL) && initDone;
  assign doneSet  = entry && (modeSel == M_NORMAL) && lmrSeen;

  always_comb begin
    strb.nop      = entry && (modeSel == M_NOP);
    strb.pre      = preOk;
    strb.lmr      = lmrOk;
    strb.passThru = passThru;
    strb.timerEn  = preSeen && ((modeSel == M_PRECH) || passThru);
    strb.pwrOk    = pwrOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrCnt   <= '0;
      prevMode <= M_NORMAL;
      nopSeen  <= 1'b0;
      preSeen  <= 1'b0;
      lmrSeen  <= 1'b0;
      initDone <= 1'b0;
      seqErr   <= 1'b0;
    end else begin
      if (!pwrOk) pwrCnt <= pwrCnt + 1'b1;
      prevMode <= modeSel;
      if (strb.nop) nopSeen <= 1'b1;
      if (preOk)    preSeen <= 1'b1;
      if (lmrOk)    lmrSeen <= 1'b1;
      if (doneSet)  initDone <= 1'b1;
      if ((preReq && !preOk) || (lmrReq && !lmrOk)) seqErr <= 1'b1;
    end
  end

  // R9: error flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    seqErr |=> seqErr);

  // R10: completion flag never drops
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  // R2: a NOP request is a single pulse
  a_r2_single_nop: assert property (@(posedge clk) disable iff (!rstN)
    strb.nop |=> !strb.nop);

  // R7: a mode load needs the refresh count reported by the datapath
  a_r7_lmr_after_refresh: assert property (@(posedge clk) disable iff (!rstN)
    strb.lmr |-> refCnt >= CNT_W'(REQ_REF));

endmodule

// File: rtl/sdram_init_dpath.sv
module sdram_init_dpath
  import sdram_init_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TMR_W = 16,
  parameter int SD_AW = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrb_t         strb,
  input  logic [TMR_W-1:0] refIval,
  input  logic [SD_AW-1:0] modeWord,
  input  logic [3:0]       userCmd,
  input  logic [SD_AW-1:0] userAddr,
  output logic [3:0]       sdCmd,
  output logic [SD_AW-1:0] sdAddr,
  output logic [CNT_W-1:0] refCnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [SD_AW-1:0] PRE_ADDR = SD_AW'(1) << A10_BIT;

  logic [TMR_W-1:0] tmrCnt;
  logic             tmrOn, tick;
  logic [3:0]       nextCmd;
  logic [SD_AW-1:0] nextAddr;

  assign tmrOn = strb.timerEn && (refIval != '0);
  assign tick  = tmrOn && (tmrCnt >= refIval - TMR_W'(1));

  always_comb begin
    nextCmd  = CMD_INH;
    nextAddr = '0;
    if (strb.nop) begin
      nextCmd = CMD_NOP;
    end else if (strb.pre) begin
      nextCmd  = CMD_PRE;
      nextAddr = PRE_ADDR;
    end else if (strb.lmr) begin
      nextCmd  = CMD_LMR;
      nextAddr = modeWord;
    end else if (tick) begin
      nextCmd = CMD_REF;
    end else if (strb.passThru) begin
      nextCmd  = userCmd;
      nextAddr = userAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt <= '0;
      refCnt <= '0;
      sdCmd  <= CMD_INH;
      sdAddr <= '0;
    end else begin
      sdCmd  <= nextCmd;
      sdAddr <= nextAddr;
      if (!tmrOn || tick) tmrCnt <= '0;
      else                tmrCnt <= tmrCnt + 1'b1;
      if (strb.pre)                         refCnt <= '0;
      else if (tick && (refCnt != CNT_MAX)) refCnt <= refCnt + 1'b1;
    end
  end

  // R3: nothing but NOP or inhibit before the power-up wait ends
  a_r3_quiet_before_wait: assert property (@(posedge clk) disable iff (!rstN)
    !strb.pwrOk |=> (sdCmd == CMD_NOP || sdCmd == CMD_INH));

  // R4: precharge request reaches the pins with all-bank bit set
  a_r4_pre_on_pins: assert property (@(posedge clk) disable iff (!rstN)
    strb.pre |=> (sdCmd == CMD_PRE && sdAddr[A10_BIT]));

  // R5: a timer expiry without a competing request becomes a refresh
  a_r5_tick_is_refresh: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strb.pre) |=> sdCmd == CMD_REF);

  // R6: zero interval never produces a refresh of its own
  a_r6_zero_ival: assert property (@(posedge clk) disable iff (!rstN)
    (refIval == '0 && !strb.passThru) |=> sdCmd != CMD_REF);

  // R12: count only grows unless a precharge clears it
  a_r12_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    !strb.pre |=> refCnt >= $past(refCnt));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int PWR_WAIT = 10000,
  parameter int REQ_REF  = 8,
  parameter int CNT_W    = 8,
  parameter int TMR_W    = 16,
  parameter int SD_AW    = 15,
  parameter int HA_W     = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             initBit,
  input  logic             modeBit,
  input  logic             widthSel,
  input  logic [TMR_W-1:0] refIval,
  input  logic             hostRd,
  input  logic [HA_W-1:0]  hostAddr,
  input  logic [3:0]       userCmd,
  input  logic [SD_AW-1:0] userAddr,
  output logic [3:0]       sdCmd,
  output logic [SD_AW-1:0] sdAddr,
  output logic [CNT_W-1:0] refreshCount,
  output logic             initDone,
  output logic             seqErr
);

  localparam int HA_HI = HA_LO + SD_AW;

  seqStrb_t         strb;
  logic [SD_AW-1:0] modeWord;
  logic             unusedHost;

  assign modeWord   = hostAddr[HA_LO +: SD_AW];
  assign unusedHost = ^{hostAddr[HA_W-1:HA_HI], hostAddr[HA_LO-1:0]};

  sdram_init_ctrl #(
    .PWR_WAIT(PWR_WAIT),
    .REQ_REF (REQ_REF),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .initBit  (initBit),
    .modeBit  (modeBit),
    .hostRd   (hostRd),
    .burstCode(modeWord[2:0]),
    .widthSel (widthSel),
    .refCnt   (refreshCount),
    .strb     (strb),
    .initDone (initDone),
    .seqErr   (seqErr)
  );

  sdram_init_dpath #(
    .CNT_W(CNT_W),
    .TMR_W(TMR_W),
    .SD_AW(SD_AW)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .refIval (refIval),
    .modeWord(modeWord),
    .userCmd (userCmd),
    .userAddr(userAddr),
    .sdCmd   (sdCmd),
    .sdAddr  (sdAddr),
    .refCnt  (refreshCount)
  );

endmodule

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;

  localparam int PW  = 40;
  localparam int REQ = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        initBit = 1'b0, modeBit = 1'b0, widthSel = 1'b0, hostRd = 1'b0;
  logic [15:0] refIval = '0;
  logic [31:0] hostAddr = '0;
  logic [3:0]  userCmd = 4'b1111;
  logic [14:0] userAddr = '0;
  logic [3:0]  sdCmd;
  logic [14:0] sdAddr;
  logic [7:0]  refreshCount;
  logic        initDone, seqErr;

  sdram_init_seq #(.PWR_WAIT(PW), .REQ_REF(REQ)) u0 (
    .clk(clk), .rstN(rstN), .initBit(initBit), .modeBit(modeBit),
    .widthSel(widthSel), .refIval(refIval), .hostRd(hostRd),
    .hostAddr(hostAddr), .userCmd(userCmd), .userAddr(userAddr),
    .sdCmd(sdCmd), .sdAddr(sdAddr), .refreshCount(refreshCount),
    .initDone(initDone), .seqErr(seqErr)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nErrs   = 0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int         mPrev, mPw, mTc, mRc;
  bit         mNop, mPre, mLmr, mDone, mErr, live;
  logic [3:0] eCmd;
  logic [14:0] eAddr;
  string      cmdTag;

  always @(posedge clk) begin
    int m, rv;
    bit entry, pwrOk, burstOk, preReq, preOk, lmrReq, lmrOk, passT, tmrOn, tick, doneSet;
    if (!rstN) begin
      mPrev = 0; mPw = 0; mTc = 0; mRc = 0;
      mNop = 0; mPre = 0; mLmr = 0; mDone = 0; mErr = 0;
      eCmd = 4'b1111; eAddr = '0; cmdTag = "R1"; live = 0;
    end else begin
      live    = 1;
      m       = {initBit, modeBit};
      rv      = refIval;
      entry   = (m != mPrev);
      pwrOk   = (mPw >= PW);
      burstOk = widthSel ? (hostAddr[13:11] == 3'd3) : (hostAddr[13:11] == 3'd2);
      preReq  = entry && m == 2;
      preOk   = preReq && pwrOk && mNop;
      lmrReq  = hostRd && m == 1;
      lmrOk   = lmrReq && pwrOk && mPre && (mRc >= REQ) && burstOk;
      passT   = (m == 0) && mDone;
      tmrOn   = mPre && (m == 2 || passT) && rv != 0;
      tick    = tmrOn && (mTc >= rv - 1);
      doneSet = entry && m == 0 && mLmr;
      eAddr   = '0;
      if (entry && m == 3) begin eCmd = 4'b0111; cmdTag = "R2"; end
      else if (preOk) begin eCmd = 4'b0010; eAddr = 15'h0400; cmdTag = "R4"; end
      else if (lmrOk) begin eCmd = 4'b0000; eAddr = hostAddr[25:11]; cmdTag = "R7"; end
      else if (tick) begin eCmd = 4'b0001; cmdTag = "R5"; end
      else if (passT) begin eCmd = userCmd; eAddr = userAddr; cmdTag = "R11"; end
      else begin
        eCmd = 4'b1111;
        if (lmrReq && !burstOk) cmdTag = "R8";
        else if (lmrReq) cmdTag = "R9";
        else if (!pwrOk) cmdTag = "R3";
        else if (rv == 0) cmdTag = "R6";
        else cmdTag = "R11";
      end
      if (mPw < PW) mPw++;
      mPrev = m;
      if (entry && m == 3) mNop = 1;
      if (preOk) mPre = 1;
      if (lmrOk) mLmr = 1;
      if (doneSet) mDone = 1;
      if ((preReq && !preOk) || (lmrReq && !lmrOk)) mErr = 1;
      if (!tmrOn || tick) mTc = 0; else mTc++;
      if (preOk) mRc = 0;
      else if (tick && mRc < 255) mRc++;
    end
  end

  always @(negedge clk) begin
    if (live && rstN) begin
      check(cmdTag, "sdCmd", 32'(sdCmd), 32'(eCmd));
      check(cmdTag, "sdAddr", 32'(sdAddr), 32'(eAddr));
      check("R12", "refreshCount", 32'(refreshCount), 32'(mRc));
      check("R10", "initDone", 32'(initDone), 32'(mDone));
      check("R9", "seqErr", 32'(seqErr), 32'(mErr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setMode(input logic i, input logic m);
    @(negedge clk);
    initBit = i; modeBit = m;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; initBit = 0; modeBit = 0; hostRd = 0;
    step(2);
    rstN = 1'b1;
  endtask

  // returns on the negedge where the resulting command is visible
  task automatic hostRead(input logic [14:0] mw);
    @(negedge clk);
    hostAddr = 32'(mw) << 11;
    hostRd   = 1'b1;
    @(negedge clk);
    hostRd   = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nErrs++; nChecks++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

  initial begin
    // ---- A1: reset state and early precharge
    doReset();
    step(1);
    check("R1", "reset sdCmd", 32'(sdCmd), 32'h0000000F);
    check("R1", "reset sdAddr", 32'(sdAddr), 32'h0);
    check("R1", "reset refreshCount", 32'(refreshCount), 32'h0);
    check("R1", "reset initDone", 32'(initDone), 32'h0);
    check("R1", "reset seqErr", 32'(seqErr), 32'h0);
    setMode(1, 0);
    step(1);
    check("R3", "early precharge refused", 32'(seqErr), 32'h1);
    check("R3", "no precharge on pins", 32'(sdCmd), 32'hF);

    // ---- A2: mode load with too few refreshes
    doReset();
    refIval = 16'd10;
    step(PW + 5);
    setMode(1, 1);
    step(2);
    setMode(1, 0);
    step(35);
    setMode(0, 1);
    step(1);
    check("R9", "count below threshold", 32'(refreshCount < 8), 32'h1);
    hostRead(15'h0022);
    check("R9", "early load refused", 32'(sdCmd), 32'hF);
    check("R9", "error flag set", 32'(seqErr), 32'h1);
    setMode(0, 0);
    userCmd = 4'b0011; userAddr = 15'h0155;
    step(3);
    check("R10", "no done without load", 32'(initDone), 32'h0);
    check("R11", "no pass before done", 32'(sdCmd), 32'hF);
    step(5);
    check("R9", "error flag sticky", 32'(seqErr), 32'h1);

    // ---- B: 16-bit path, full sequence
    doReset();
    widthSel = 1'b1; refIval = 16'd0;
    step(PW + 3);
    setMode(1, 1);
    step(1);
    check("R2", "NOP on pins", 32'(sdCmd), 32'h7);
    step(1);
    check("R2", "single NOP", 32'(sdCmd), 32'hF);
    setMode(1, 0);
    step(1);
    check("R4", "precharge cmd", 32'(sdCmd), 32'h2);
    check("R4", "precharge all banks", 32'(sdAddr), 32'h400);
    step(30);
    check("R6", "zero interval no refresh", 32'(refreshCount), 32'h0);
    refIval = 16'd10;
    step(85);
    check("R5", "eight refreshes", 32'(refreshCount >= 8), 32'h1);
    setMode(0, 1);
    step(2);
    hostRead(15'h0032);
    check("R8", "BL4 code refused on 16-bit", 32'(seqErr), 32'h1);
    check("R8", "no load on pins", 32'(sdCmd), 32'hF);
    hostRead(15'h0033);
    check("R7", "load mode cmd", 32'(sdCmd), 32'h0);
    check("R7", "mode word on address", 32'(sdAddr), 32'h33);
    setMode(0, 0);
    step(2);
    check("R10", "done after load", 32'(initDone), 32'h1);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      userCmd  = 4'(i % 7);
      userAddr = 15'(i * 37 + 5);
    end
    refIval = 16'd1;
    step(300);
    check("R12", "count saturates", 32'(refreshCount), 32'hFF);
    check("R10", "done stays", 32'(initDone), 32'h1);

    // ---- C: 32-bit path, short interval
    doReset();
    widthSel = 1'b0; refIval = 16'd2;
    userCmd = 4'b0101;
    step(PW + 2);
    setMode(1, 1);
    step(1);
    setMode(1, 0);
    step(22);
    setMode(0, 1);
    step(1);
    hostRead(15'h0022);
    check("R8", "BL4 accepted on 32-bit", 32'(sdCmd), 32'h0);
    check("R7", "mode word 32-bit", 32'(sdAddr), 32'h22);
    setMode(0, 0);
    step(12);
    check("R10", "done 32-bit", 32'(initDone), 32'h1);
    check("R9", "no error on clean run", 32'(seqErr), 32'h0);

    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

endmodule